// File: doc/BRIEF.md
# Watchdog Clock and Service Selector

This block chooses what advances a watchdog and decides which software write counts as servicing it. One configuration bit picks the tick source: either the underflow pulse of a general-purpose timer or a prescaled slow-clock pulse. The chosen pulse comes out as a one-cycle tick enable. A second bit picks the service method. In direct mode, writing a count value both stores it and reloads the watchdog. In match mode, only a write of the byte 5Ch to a separate match register reloads the watchdog from the stored value.

A small down-counter is included so that servicing and expiry can be seen at the ports. It is reloaded on every accepted service and decremented on every tick. It raises a one-cycle timeout pulse when a tick moves it from one to zero. A lock input freezes the count register against writes. The configuration and lock inputs are expected to come from a register block elsewhere, and reset generation is handled outside.

Top module: `wdog_svc_sel`

## Requirements
- R1: With `clkSelSlow` = 0, `wdTickEn` follows `t0Underflow` in the same cycle, and `slowTick` is ignored.
- R2: With `clkSelSlow` = 1, `wdTickEn` follows `slowTick` in the same cycle, and `t0Underflow` is ignored.
- R3: With `matchMode` = 0 and `lockCount` = 0, a count write raises `reloadPulse` in the same cycle. In that cycle `reloadValue` equals the written data. After the clock edge, `wdCount` equals the written data and the stored reload value is updated.
- R4: With `matchMode` = 0, a write to the match register has no effect, whatever its data (5Ch included). `reloadPulse` stays low and `wdCount` is unchanged.
- R5: With `matchMode` = 1, a match write whose data is exactly 5Ch raises `reloadPulse`. `reloadValue` equals the stored count value, and `wdCount` takes that value after the edge.
- R6: With `matchMode` = 1, a match write with any data other than 5Ch does not raise `reloadPulse` and leaves `wdCount` unchanged.
- R7: With `matchMode` = 1, an unlocked count write only updates the stored reload value. It raises no `reloadPulse` and leaves `wdCount` unchanged, and a later 5Ch match write loads the new value.
- R8: While `lockCount` = 1, count writes neither update the stored value nor reload the counter.
- R9: Each tick with no service decrements `wdCount` by one. At zero the counter holds, and further ticks change nothing.
- R10: `timeout` is high for exactly one cycle, in the cycle after the edge at which a tick moves `wdCount` from 1 to 0. It stays low when ticks arrive with the counter already at zero.
- R11: When a tick and a service occur in the same cycle, the service wins. `wdCount` takes the reload value and is not decremented.
- R12: After reset, `wdCount` and the stored reload value are all ones (FFh), and `timeout` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSelSlow | input | 1 | Tick source: 0 timer underflow, 1 slow-clock tick |
| matchMode | input | 1 | Service method: 0 count write, 1 match write of 5Ch |
| lockCount | input | 1 | When 1, count register writes are ignored |
| slowTick | input | 1 | One-cycle prescaled slow-clock pulse |
| t0Underflow | input | 1 | One-cycle timer-0 underflow pulse |
| cntWrEn | input | 1 | Count register write strobe |
| cntWrData | input | CNT_W | Count register write data |
| matchWrEn | input | 1 | Match register write strobe |
| matchWrData | input | 8 | Match register write data |
| wdTickEn | output | 1 | Selected watchdog tick enable |
| reloadPulse | output | 1 | Accepted service this cycle |
| reloadValue | output | CNT_W | Value loaded by the service |
| wdCount | output | CNT_W | Current watchdog count |
| timeout | output | 1 | One-cycle expiry pulse |

## Verification
Both tick sources are pulsed one at a time under each setting of the select bit. This shows that exactly one source is routed and the other is dropped. Match writes carrying 5Ch and carrying a neighbouring value (5Bh) are applied in both service modes, and count writes are applied in both modes and under lock. Together these separate a real service from a stored-only value and from an ignored write. Finally, the counter is run from two down to zero and then ticked once more, and a tick is applied together with a service in the same cycle. This shows the single timeout pulse, the hold at zero, and the priority of service over tick.

// File: rtl/wdsel_pkg.sv
package wdsel_pkg;
  localparam logic [7:0] SVC_MAGIC = 8'h5C;

  typedef struct packed {
    logic tick;       // watchdog advances this cycle
    logic reload;     // accepted service this cycle
    logic store;      // update stored reload value
    logic useWrData;  // reload value comes from the count write data
  } wdStrobes_t;
endpackage

// File: rtl/wdsel_ctrl.sv
module wdsel_ctrl
  import wdsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkSelSlow,
  input  logic       matchMode,
  input  logic       lockCount,
  input  logic       slowTick,
  input  logic       t0Underflow,
  input  logic       cntWrEn,
  input  logic       matchWrEn,
  input  logic [7:0] matchWrData,
  output wdStrobes_t strobes
);
  logic cntWrOk;
  logic magicHit;

  assign cntWrOk  = cntWrEn && !lockCount;
  assign magicHit = matchWrEn && (matchWrData == SVC_MAGIC);

  always_comb begin
    strobes           = '0;
    strobes.tick      = clkSelSlow ? slowTick : t0Underflow;
    strobes.store     = cntWrOk;
    strobes.useWrData = !matchMode;
    if (matchMode) strobes.reload = magicHit;
    else           strobes.reload = cntWrOk;
  end

  // R4: in direct mode only count writes may service
  p_match_ignored_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!matchMode && !cntWrEn) |-> !strobes.reload);

  // R6: wrong byte never services in match mode
  p_bad_magic_r6: assert property (@(posedge clk) disable iff (!rstN)
    (matchMode && matchWrData != 8'h5C) |-> !strobes.reload);

  // R8: locked count writes are dropped
  p_lock_r8: assert property (@(posedge clk) disable iff (!rstN)
    lockCount |-> (!strobes.store && (matchMode || !strobes.reload)));

  // R1/R2: tick enable only from the selected source
  p_tick_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkSelSlow && !t0Underflow) |-> !strobes.tick);
  p_tick_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelSlow && !slowTick) |-> !strobes.tick);
endmodule

// File: rtl/wdsel_datapath.sv
module wdsel_datapath
  import wdsel_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobes_t       strobes,
  input  logic [CNT_W-1:0] cntWrData,
  output logic [CNT_W-1:0] reloadValue,
  output logic [CNT_W-1:0] count,
  output logic             timeout
);
  localparam logic [CNT_W-1:0] RESET_VAL = '1;
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [CNT_W-1:0] storedVal;

  assign reloadValue = strobes.useWrData ? cntWrData : storedVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedVal <= RESET_VAL;
    end else if (strobes.store) begin
      storedVal <= cntWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= RESET_VAL;
      timeout <= 1'b0;
    end else if (strobes.reload) begin
      count   <= reloadValue;
      timeout <= 1'b0;
    end else if (strobes.tick && count != '0) begin
      count   <= count - ONE;
      timeout <= (count == ONE);
    end else begin
      timeout <= 1'b0;
    end
  end

  // R3/R5/R11: a service loads the offered value
  p_reload_loads_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reload |=> (count == $past(reloadValue)));

  // R9: an unserviced tick decrements a nonzero count
  p_tick_dec_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.reload && count != '0) |=> (count == $past(count) - ONE));

  // R9: nothing moves without a tick or service
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.reload) |=> $stable(count));

  // R10: timeout lasts one cycle
  p_timeout_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);

  // R10: timeout only with a zero count
  p_timeout_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeout |-> (count == '0));
endmodule

// File: rtl/wdog_svc_sel.sv
module wdog_svc_sel
  import wdsel_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkSelSlow,
  input  logic             matchMode,
  input  logic             lockCount,
  input  logic             slowTick,
  input  logic             t0Underflow,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             matchWrEn,
  input  logic [7:0]       matchWrData,
  output logic             wdTickEn,
  output logic             reloadPulse,
  output logic [CNT_W-1:0] reloadValue,
  output logic [CNT_W-1:0] wdCount,
  output logic             timeout
);
  wdStrobes_t strobes;

  wdsel_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .clkSelSlow (clkSelSlow),
    .matchMode  (matchMode),
    .lockCount  (lockCount),
    .slowTick   (slowTick),
    .t0Underflow(t0Underflow),
    .cntWrEn    (cntWrEn),
    .matchWrEn  (matchWrEn),
    .matchWrData(matchWrData),
    .strobes    (strobes)
  );

  wdsel_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cntWrData  (cntWrData),
    .reloadValue(reloadValue),
    .count      (wdCount),
    .timeout    (timeout)
  );

  assign wdTickEn    = strobes.tick;
  assign reloadPulse = strobes.reload;
endmodule

// File: tb/wdog_svc_sel_bench.sv
module wdog_svc_sel_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkSelSlow = 1'b0, matchMode = 1'b0, lockCount = 1'b0;
  logic       slowTick = 1'b0, t0Underflow = 1'b0;
  logic       cntWrEn = 1'b0, matchWrEn = 1'b0;
  logic [7:0] cntWrData = '0, matchWrData = '0;
  logic       wdTickEn, reloadPulse, timeout;
  logic [7:0] reloadValue, wdCount;

  int testsRun = 0;
  int testsFailed = 0;
  logic obsTick, obsRel;
  logic [7:0] obsRelVal;

  always #5 clk = ~clk;

  wdog_svc_sel u_wdog_svc_sel (
    .clk(clk), .rstN(rstN), .clkSelSlow(clkSelSlow), .matchMode(matchMode),
    .lockCount(lockCount), .slowTick(slowTick), .t0Underflow(t0Underflow),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .matchWrEn(matchWrEn),
    .matchWrData(matchWrData), .wdTickEn(wdTickEn), .reloadPulse(reloadPulse),
    .reloadValue(reloadValue), .wdCount(wdCount), .timeout(timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Starts at a negedge; holds the given strobes for one cycle and
  // ends at the next negedge with registered outputs updated.
  task automatic cycle(input logic t0, input logic sl, input logic cw,
                       input logic [7:0] cd, input logic mw, input logic [7:0] md);
    t0Underflow = t0; slowTick = sl;
    cntWrEn = cw; cntWrData = cd;
    matchWrEn = mw; matchWrData = md;
    #1;
    obsTick = wdTickEn; obsRel = reloadPulse; obsRelVal = reloadValue;
    @(negedge clk);
    t0Underflow = 0; slowTick = 0; cntWrEn = 0; matchWrEn = 0;
  endtask

  task automatic test_reset;
    check("R12 count", wdCount, 8'hFF);
    check("R12 timeout", timeout, 0);
  endtask

  task automatic test_tick_select;
    clkSelSlow = 0;
    cycle(1, 0, 0, 0, 0, 0);
    check("R1 t0 routed", obsTick, 1);
    check("R9 decrement", wdCount, 8'hFE);
    cycle(0, 1, 0, 0, 0, 0);
    check("R1 slow ignored", obsTick, 0);
    check("R1 count held", wdCount, 8'hFE);
    clkSelSlow = 1;
    cycle(0, 1, 0, 0, 0, 0);
    check("R2 slow routed", obsTick, 1);
    check("R2 decrement", wdCount, 8'hFD);
    cycle(1, 0, 0, 0, 0, 0);
    check("R2 t0 ignored", obsTick, 0);
    check("R2 count held", wdCount, 8'hFD);
    clkSelSlow = 0;
  endtask

  task automatic test_direct_mode;
    matchMode = 0;
    cycle(0, 0, 1, 8'h10, 0, 0);
    check("R3 pulse", obsRel, 1);
    check("R3 value", obsRelVal, 8'h10);
    check("R3 count", wdCount, 8'h10);
    cycle(0, 0, 0, 0, 1, 8'h5C);
    check("R4 no pulse", obsRel, 0);
    check("R4 count", wdCount, 8'h10);
  endtask

  task automatic test_lock;
    lockCount = 1;
    cycle(0, 0, 1, 8'h33, 0, 0);
    check("R8 no pulse", obsRel, 0);
    check("R8 count", wdCount, 8'h10);
    matchMode = 1;
    cycle(0, 0, 1, 8'h44, 0, 0);
    lockCount = 0;
    cycle(0, 0, 0, 0, 1, 8'h5C);
    check("R8 stored kept", obsRelVal, 8'h10);
    check("R8 count", wdCount, 8'h10);
  endtask

  task automatic test_match_mode;
    matchMode = 1;
    cycle(0, 0, 1, 8'h20, 0, 0);
    check("R7 no pulse", obsRel, 0);
    check("R7 count", wdCount, 8'h10);
    cycle(0, 0, 0, 0, 1, 8'h5B);
    check("R6 no pulse", obsRel, 0);
    check("R6 count", wdCount, 8'h10);
    cycle(0, 0, 0, 0, 1, 8'h5C);
    check("R5 pulse", obsRel, 1);
    check("R5 value", obsRelVal, 8'h20);
    check("R7 new value loaded", wdCount, 8'h20);
  endtask

  task automatic test_timeout;
    matchMode = 0; clkSelSlow = 0;
    cycle(0, 0, 1, 8'h02, 0, 0);
    check("R3 count two", wdCount, 8'h02);
    cycle(1, 0, 0, 0, 0, 0);
    check("R9 count one", wdCount, 8'h01);
    check("R10 no early timeout", timeout, 0);
    cycle(1, 0, 0, 0, 0, 0);
    check("R10 count zero", wdCount, 8'h00);
    check("R10 timeout high", timeout, 1);
    cycle(0, 0, 0, 0, 0, 0);
    check("R10 timeout drops", timeout, 0);
    cycle(1, 0, 0, 0, 0, 0);
    check("R9 hold at zero", wdCount, 8'h00);
    check("R10 no repeat", timeout, 0);
  endtask

  task automatic test_collision;
    matchMode = 0; clkSelSlow = 0;
    cycle(1, 0, 1, 8'h05, 0, 0);
    check("R11 direct service wins", wdCount, 8'h05);
    matchMode = 1;
    cycle(1, 0, 0, 0, 0, 0);
    check("R11 tick alone", wdCount, 8'h04);
    cycle(1, 0, 0, 0, 1, 8'h5C);
    check("R11 match service wins", wdCount, 8'h05);
    matchMode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    test_reset();
    test_tick_select();
    test_direct_mode();
    test_lock();
    test_match_mode();
    test_timeout();
    test_collision();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #100000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule